// File: doc/BRIEF.md
# Conditional Branch Evaluator

This unit settles the control-flow outcome of a relative branch. A request carries the branch opcode, a signed 8-bit displacement, the address of the branch instruction and the current condition-code byte. One clock edge later the unit reports several values:
- whether control transfers;
- the next program counter, which is either the branch target or the fall-through address;
- for the subroutine form, the return address that the sequencer must push;
- the cycle cost of the instruction.

The unit reads the negative, zero, overflow and carry flags. From them it evaluates the whole family of plain, unsigned and signed comparisons. It passes the condition byte back unchanged, so a sequencer can write it back without checking which instruction ran.

Opcodes outside the branch group are not handled here. The unit marks them as unknown and reports the fall-through address for them. Flag bit positions, opcode codes, address width and cycle costs are parameters. A parameter also picks one of two adder arrangements.

Top module: `brcond_unit`

## Requirements
- R1: While reset is asserted and until the first accepted request, every output is zero.
- R2: An accepted request (req_valid high at a rising edge) produces rsp_valid high for exactly the following cycle. In cycles without a request, rsp_valid is low and all result outputs keep their last values, whatever the request inputs carry.
- R3: Opcode 0x20 is always taken, and opcode 0x21 is never taken.
- R4: The unsigned and carry tests read carry at condition bit 0 and zero at bit 2. Opcode 0x22 is taken when (C or Z) is 0, and 0x23 when (C or Z) is 1. Opcode 0x24 is taken when C is 0, and 0x25 when C is 1.
- R5: The single-flag tests read zero at bit 2, overflow at bit 1 and negative at bit 3. They work as follows:
  - 0x26 is taken when Z is clear, and 0x27 when Z is set.
  - 0x28 is taken when V is clear, and 0x29 when V is set.
  - 0x2A is taken when N is clear, and 0x2B when N is set.
- R6: The signed tests are:
  - 0x2C is taken when (N xor V) is 0, and 0x2D when it is 1.
  - 0x2E is taken when Z or (N xor V) is 0, and 0x2F when it is 1.
- R7: The target is PC + 2 + the sign-extended displacement, modulo 65536. rsp_next_pc is the target when taken and PC + 2 otherwise.
- R8: Opcode 0x8D is always taken. It raises rsp_sub and gives rsp_ret_addr = PC + 2 (modulo 65536). For every other opcode, rsp_sub and rsp_ret_addr are 0.
- R9: Any opcode other than 0x20 to 0x2F and 0x8D gives the following: rsp_known = 0, not taken, rsp_next_pc = PC + 2, and rsp_cycles = 0. Known opcodes give rsp_known = 1.
- R10: rsp_cycles is 4 for opcodes 0x20 to 0x2F and 8 for 0x8D.
- R11: rsp_ccr equals the request's full condition byte, all eight bits, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_opcode | input | 8 | Instruction opcode |
| req_disp | input | 8 | Signed relative displacement |
| req_pc | input | 16 | Address of the branch instruction |
| req_ccr | input | 8 | Condition-code byte |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_taken | output | 1 | Branch transfers control |
| rsp_next_pc | output | 16 | Next program counter |
| rsp_sub | output | 1 | Subroutine branch, return address must be pushed |
| rsp_ret_addr | output | 16 | Return address for the subroutine form |
| rsp_cycles | output | 4 | Instruction cycle cost |
| rsp_known | output | 1 | Opcode belongs to the handled set |
| rsp_ccr | output | 8 | Condition byte returned unchanged |

## Verification
The subroutine branch yields two addresses in the same cycle: the jump target and the return address. Both come from one instruction address, and one of them also adds the displacement. The bench provokes this with subroutine requests whose address sits at the top of memory and whose displacement is at either signed extreme, so both sums wrap in one response. A behavioural model computes both sums with integer arithmetic, and the bench compares both on that response. The same comparison runs on back-to-back requests, where a result is loaded in the same cycle the previous one is presented.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } nzvc_t;

   typedef enum logic [1:0] {
      BK_NONE = 2'd0,
      BK_COND = 2'd1,
      BK_SUB  = 2'd2
   } br_kind_e;

   localparam int PRED_COUNT = 8;

   // Predicate for the "odd" opcode of each pair; the even opcode takes its inverse.
   function automatic logic pred_odd_sense(input int idx, input nzvc_t f);
      logic r;
      case (idx)
         0:       r = 1'b0;
         1:       r = f.c | f.z;
         2:       r = f.c;
         3:       r = f.z;
         4:       r = f.v;
         5:       r = f.n;
         6:       r = f.n ^ f.v;
         7:       r = f.z | (f.n ^ f.v);
         default: r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/brcond_flag_extract.sv
module brcond_flag_extract #(
   parameter int CC_W  = 8,
   parameter int N_BIT = 3,
   parameter int Z_BIT = 2,
   parameter int V_BIT = 1,
   parameter int C_BIT = 0
) (
   input  logic [CC_W-1:0]     ccr,
   output brcond_pkg::nzvc_t   flags
);

   if (CC_W < 4) begin : g_bad_width
      $error("brcond_flag_extract: CC_W must be at least 4");
   end
   if (N_BIT >= CC_W || Z_BIT >= CC_W || V_BIT >= CC_W || C_BIT >= CC_W) begin : g_bad_pos
      $error("brcond_flag_extract: flag position outside the condition byte");
   end
   if (N_BIT == Z_BIT || N_BIT == V_BIT || N_BIT == C_BIT ||
       Z_BIT == V_BIT || Z_BIT == C_BIT || V_BIT == C_BIT) begin : g_bad_overlap
      $error("brcond_flag_extract: flag positions must be distinct");
   end

   assign flags.n = ccr[N_BIT];
   assign flags.z = ccr[Z_BIT];
   assign flags.v = ccr[V_BIT];
   assign flags.c = ccr[C_BIT];

endmodule

// File: rtl/brcond_cond_eval.sv
module brcond_cond_eval #(
   parameter int              OP_W    = 8,
   parameter logic [OP_W-1:0] BR_BASE = 'h20,
   parameter logic [OP_W-1:0] SUB_OP  = 'h8D
) (
   input  logic [OP_W-1:0]       opcode,
   input  brcond_pkg::nzvc_t     flags,
   output brcond_pkg::br_kind_e  kind,
   output logic                  cond_met
);
   import brcond_pkg::*;

   localparam int SEL_W   = 4;
   localparam int N_CONDS = 2 * PRED_COUNT;

   if (OP_W <= SEL_W) begin : g_bad_opw
      $error("brcond_cond_eval: OP_W must exceed the selector width");
   end
   if (BR_BASE[SEL_W-1:0] != '0) begin : g_bad_base
      $error("brcond_cond_eval: branch group base must be 16-aligned");
   end
   if (SUB_OP[OP_W-1:SEL_W] == BR_BASE[OP_W-1:SEL_W]) begin : g_bad_sub
      $error("brcond_cond_eval: subroutine opcode collides with branch group");
   end

   logic [N_CONDS-1:0] met_vec;

   for (genvar k = 0; k < PRED_COUNT; k++) begin : g_pair
      logic odd_p;
      assign odd_p            = pred_odd_sense(k, flags);
      assign met_vec[2*k]     = ~odd_p;
      assign met_vec[2*k + 1] =  odd_p;
   end

   logic in_group;
   logic is_sub;

   assign in_group = (opcode[OP_W-1:SEL_W] == BR_BASE[OP_W-1:SEL_W]);
   assign is_sub   = (opcode == SUB_OP);

   always_comb begin
      kind     = BK_NONE;
      cond_met = 1'b0;
      if (in_group) begin
         kind     = BK_COND;
         cond_met = met_vec[opcode[SEL_W-1:0]];
      end else if (is_sub) begin
         kind     = BK_SUB;
         cond_met = 1'b1;
      end
   end

endmodule

// File: rtl/brcond_target.sv
module brcond_target #(
   parameter int ADDR_W      = 16,
   parameter int DISP_W      = 8,
   parameter int INSTR_LEN   = 2,
   parameter int ADDER_STYLE = 1
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] seq_pc,
   output logic [ADDR_W-1:0] target
);

   localparam logic [ADDR_W-1:0] LEN_C = ADDR_W'(INSTR_LEN);

   if (DISP_W > ADDR_W) begin : g_bad_disp
      $error("brcond_target: displacement wider than address");
   end
   if (ADDER_STYLE < 0 || ADDER_STYLE > 1) begin : g_bad_style
      $error("brcond_target: ADDER_STYLE must be 0 or 1");
   end

   logic [ADDR_W-1:0] disp_ext;

   if (DISP_W == ADDR_W) begin : g_no_ext
      assign disp_ext = disp;
   end else begin : g_sign_ext
      assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
   end

   assign seq_pc = pc + LEN_C;

   if (ADDER_STYLE == 0) begin : g_three_op
      // Independent three-operand sum: no dependency on the fall-through adder.
      assign target = pc + LEN_C + disp_ext;
   end else begin : g_chained
      // Reuses the fall-through sum: one adder fewer, one adder deeper.
      assign target = seq_pc + disp_ext;
   end

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit #(
   parameter int   ADDR_W      = 16,
   parameter int   DISP_W      = 8,
   parameter int   OP_W        = 8,
   parameter int   CC_W        = 8,
   parameter int   CYC_W       = 4,
   parameter int   INSTR_LEN   = 2,
   parameter int   COND_CYC    = 4,
   parameter int   SUB_CYC     = 8,
   parameter int   ADDER_STYLE = 1,
   parameter int   N_BIT       = 3,
   parameter int   Z_BIT       = 2,
   parameter int   V_BIT       = 1,
   parameter int   C_BIT       = 0,
   parameter logic [OP_W-1:0] BR_BASE = 'h20,
   parameter logic [OP_W-1:0] SUB_OP  = 'h8D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [OP_W-1:0]   req_opcode,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [ADDR_W-1:0] req_pc,
   input  logic [CC_W-1:0]   req_ccr,
   output logic              rsp_valid,
   output logic              rsp_taken,
   output logic [ADDR_W-1:0] rsp_next_pc,
   output logic              rsp_sub,
   output logic [ADDR_W-1:0] rsp_ret_addr,
   output logic [CYC_W-1:0]  rsp_cycles,
   output logic              rsp_known,
   output logic [CC_W-1:0]   rsp_ccr
);
   import brcond_pkg::*;

   localparam int CYC_MAX = (1 << CYC_W) - 1;

   if (COND_CYC > CYC_MAX || SUB_CYC > CYC_MAX) begin : g_bad_cyc
      $error("brcond_unit: cycle cost does not fit CYC_W");
   end
   if (INSTR_LEN < 1) begin : g_bad_len
      $error("brcond_unit: INSTR_LEN must be positive");
   end

   nzvc_t             flags;
   br_kind_e          kind;
   logic              cond_met;
   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] target;

   brcond_flag_extract #(
      .CC_W (CC_W), .N_BIT(N_BIT), .Z_BIT(Z_BIT), .V_BIT(V_BIT), .C_BIT(C_BIT)
   ) u_flags (
      .ccr  (req_ccr),
      .flags(flags)
   );

   brcond_cond_eval #(
      .OP_W(OP_W), .BR_BASE(BR_BASE), .SUB_OP(SUB_OP)
   ) u_eval (
      .opcode  (req_opcode),
      .flags   (flags),
      .kind    (kind),
      .cond_met(cond_met)
   );

   brcond_target #(
      .ADDR_W(ADDR_W), .DISP_W(DISP_W), .INSTR_LEN(INSTR_LEN), .ADDER_STYLE(ADDER_STYLE)
   ) u_target (
      .pc    (req_pc),
      .disp  (req_disp),
      .seq_pc(seq_pc),
      .target(target)
   );

   logic              taken_d;
   logic              sub_d;
   logic [ADDR_W-1:0] next_d;
   logic [ADDR_W-1:0] ret_d;
   logic [CYC_W-1:0]  cyc_d;

   always_comb begin
      taken_d = (kind != BK_NONE) && cond_met;
      sub_d   = (kind == BK_SUB);
      next_d  = taken_d ? target : seq_pc;
      ret_d   = sub_d ? seq_pc : '0;
      case (kind)
         BK_COND: cyc_d = CYC_W'(COND_CYC);
         BK_SUB:  cyc_d = CYC_W'(SUB_CYC);
         default: cyc_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_taken    <= 1'b0;
         rsp_next_pc  <= '0;
         rsp_sub      <= 1'b0;
         rsp_ret_addr <= '0;
         rsp_cycles   <= '0;
         rsp_known    <= 1'b0;
         rsp_ccr      <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_taken    <= taken_d;
            rsp_next_pc  <= next_d;
            rsp_sub      <= sub_d;
            rsp_ret_addr <= ret_d;
            rsp_cycles   <= cyc_d;
            rsp_known    <= (kind != BK_NONE);
            rsp_ccr      <= req_ccr;
         end
      end
   end

endmodule

// File: rtl/brcond_unit_chk.sv
module brcond_unit_chk #(
   parameter int   ADDR_W    = 16,
   parameter int   DISP_W    = 8,
   parameter int   OP_W      = 8,
   parameter int   CC_W      = 8,
   parameter int   CYC_W     = 4,
   parameter int   INSTR_LEN = 2,
   parameter int   SUB_CYC   = 8,
   parameter logic [OP_W-1:0] BR_BASE = 'h20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [OP_W-1:0]   req_opcode,
   input logic [DISP_W-1:0] req_disp,
   input logic [ADDR_W-1:0] req_pc,
   input logic [CC_W-1:0]   req_ccr,
   input logic              rsp_valid,
   input logic              rsp_taken,
   input logic [ADDR_W-1:0] rsp_next_pc,
   input logic              rsp_sub,
   input logic [ADDR_W-1:0] rsp_ret_addr,
   input logic [CYC_W-1:0]  rsp_cycles,
   input logic              rsp_known,
   input logic [CC_W-1:0]   rsp_ccr
);

   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rsp_valid == $past(req_valid)));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !rsp_valid) |->
         ($stable(rsp_next_pc) && $stable(rsp_taken) && $stable(rsp_ccr) && $stable(rsp_ret_addr)));

   p_always_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_opcode) == BR_BASE) |-> rsp_taken);

   p_never_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_opcode) == BR_BASE + 1'b1) |-> !rsp_taken);

   p_fallthrough_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_taken) |-> (rsp_next_pc == ADDR_W'($past(req_pc) + ADDR_W'(INSTR_LEN))));

   p_sub_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_sub) |->
         (rsp_taken && rsp_cycles == CYC_W'(SUB_CYC) &&
          rsp_ret_addr == ADDR_W'($past(req_pc) + ADDR_W'(INSTR_LEN))));

   p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_known) |-> (!rsp_taken && !rsp_sub && rsp_cycles == '0));

   p_ccr_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_ccr == $past(req_ccr)));

endmodule

bind brcond_unit brcond_unit_chk #(
   .ADDR_W(ADDR_W), .DISP_W(DISP_W), .OP_W(OP_W), .CC_W(CC_W), .CYC_W(CYC_W),
   .INSTR_LEN(INSTR_LEN), .SUB_CYC(SUB_CYC), .BR_BASE(BR_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
   .req_disp(req_disp), .req_pc(req_pc), .req_ccr(req_ccr),
   .rsp_valid(rsp_valid), .rsp_taken(rsp_taken), .rsp_next_pc(rsp_next_pc),
   .rsp_sub(rsp_sub), .rsp_ret_addr(rsp_ret_addr), .rsp_cycles(rsp_cycles),
   .rsp_known(rsp_known), .rsp_ccr(rsp_ccr)
);

// File: tb/brcond_unit_bench.sv
`timescale 1ns/1ps
module brcond_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_opcode = '0;
   logic [7:0]  req_disp = '0;
   logic [15:0] req_pc = '0;
   logic [7:0]  req_ccr = '0;
   logic        rsp_valid;
   logic        rsp_taken;
   logic [15:0] rsp_next_pc;
   logic        rsp_sub;
   logic [15:0] rsp_ret_addr;
   logic [3:0]  rsp_cycles;
   logic        rsp_known;
   logic [7:0]  rsp_ccr;

   int n_checks = 0;
   int n_fails  = 0;
   bit chk_on   = 1'b0;

   always #10 clk = ~clk;

   brcond_unit u_brcond_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
      .req_disp(req_disp), .req_pc(req_pc), .req_ccr(req_ccr),
      .rsp_valid(rsp_valid), .rsp_taken(rsp_taken), .rsp_next_pc(rsp_next_pc),
      .rsp_sub(rsp_sub), .rsp_ret_addr(rsp_ret_addr), .rsp_cycles(rsp_cycles),
      .rsp_known(rsp_known), .rsp_ccr(rsp_ccr)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference: integer arithmetic and an explicit opcode table.
   task automatic ref_eval(input int op, input int disp, input int pc, input int ccr,
                           output bit tk, output int nxt, output bit sb, output int ret,
                           output int cyc, output bit kn, output string tag);
      bit n, z, v, c;
      int d, seq, tgt;
      n = ccr[3]; z = ccr[2]; v = ccr[1]; c = ccr[0];
      d   = (disp >= 128) ? disp - 256 : disp;
      seq = (pc + 2) % 65536;
      tgt = (pc + 2 + d + 65536) % 65536;
      kn = 1'b1; sb = 1'b0; cyc = 4; tk = 1'b0;
      case (op)
         'h20: begin tk = 1'b1;             tag = "R3"; end
         'h21: begin tk = 1'b0;             tag = "R3"; end
         'h22: begin tk = !(c || z);        tag = "R4"; end
         'h23: begin tk = (c || z);         tag = "R4"; end
         'h24: begin tk = !c;               tag = "R4"; end
         'h25: begin tk = c;                tag = "R4"; end
         'h26: begin tk = !z;               tag = "R5"; end
         'h27: begin tk = z;                tag = "R5"; end
         'h28: begin tk = !v;               tag = "R5"; end
         'h29: begin tk = v;                tag = "R5"; end
         'h2A: begin tk = !n;               tag = "R5"; end
         'h2B: begin tk = n;                tag = "R5"; end
         'h2C: begin tk = (n == v);         tag = "R6"; end
         'h2D: begin tk = (n != v);         tag = "R6"; end
         'h2E: begin tk = !z && (n == v);   tag = "R6"; end
         'h2F: begin tk = z || (n != v);    tag = "R6"; end
         'h8D: begin tk = 1'b1; sb = 1'b1; cyc = 8; tag = "R8"; end
         default: begin kn = 1'b0; cyc = 0; tag = "R9"; end
      endcase
      nxt = tk ? tgt : seq;
      ret = sb ? seq : 0;
   endtask

   bit    m_valid, m_taken, m_sub, m_known;
   int    m_next, m_ret, m_cyc, m_ccr;
   string m_tag = "R1";

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid <= 0; m_taken <= 0; m_sub <= 0; m_known <= 0;
         m_next <= 0; m_ret <= 0; m_cyc <= 0; m_ccr <= 0; m_tag <= "R1";
      end else begin
         m_valid <= req_valid;
         if (req_valid) begin
            bit tk, sb, kn;
            int nx, rt, cy;
            string tg;
            ref_eval(int'(req_opcode), int'(req_disp), int'(req_pc), int'(req_ccr),
                     tk, nx, sb, rt, cy, kn, tg);
            m_taken <= tk; m_next <= nx; m_sub <= sb; m_ret <= rt;
            m_cyc <= cy; m_known <= kn; m_ccr <= int'(req_ccr); m_tag <= tg;
         end
      end
   end

   // Compare every clock, away from the active edge.
   always @(negedge clk) begin
      if (chk_on) begin
         check(rsp_valid == m_valid, "R2", "valid", rsp_valid, m_valid);
         check(rsp_taken == m_taken, m_tag, "taken", rsp_taken, m_taken);
         check(int'(rsp_next_pc) == m_next, (m_known ? "R7" : "R9"), "next_pc", rsp_next_pc, m_next);
         check(rsp_sub == m_sub, "R8", "sub", rsp_sub, m_sub);
         check(int'(rsp_ret_addr) == m_ret, "R8", "ret_addr", rsp_ret_addr, m_ret);
         check(int'(rsp_cycles) == m_cyc, "R10", "cycles", rsp_cycles, m_cyc);
         check(rsp_known == m_known, "R9", "known", rsp_known, m_known);
         check(int'(rsp_ccr) == m_ccr, "R11", "ccr", rsp_ccr, m_ccr);
      end
   end

   task automatic send(input int op, input int disp, input int pc, input int ccr);
      @(negedge clk);
      req_valid  = 1'b1;
      req_opcode = 8'(op);
      req_disp   = 8'(disp);
      req_pc     = 16'(pc);
      req_ccr    = 8'(ccr);
   endtask

   task automatic idle(input int salt);
      @(negedge clk);
      req_valid  = 1'b0;
      req_opcode = 8'(salt * 7 + 3);
      req_disp   = 8'(salt * 11);
      req_pc     = 16'(salt * 4099);
      req_ccr    = 8'(salt * 5 + 1);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: outputs held at zero in reset, even with a request pending.
      req_valid = 1'b1; req_opcode = 8'h20; req_pc = 16'h1234; req_ccr = 8'hFF;
      repeat (3) @(negedge clk);
      check(rsp_valid == 0 && rsp_taken == 0 && rsp_sub == 0 && rsp_known == 0,
            "R1", "reset flags", {rsp_valid, rsp_taken, rsp_sub, rsp_known}, 0);
      check(rsp_next_pc == 0 && rsp_ret_addr == 0 && rsp_cycles == 0 && rsp_ccr == 0,
            "R1", "reset data", rsp_next_pc, 0);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 0 && rsp_next_pc == 0 && rsp_ccr == 0,
            "R1", "after release", rsp_next_pc, 0);
      chk_on = 1'b1;

      // R3..R7, R10, R11: every conditional opcode against every flag pattern.
      for (int op = 'h20; op <= 'h2F; op++) begin
         for (int f = 0; f < 16; f++) begin
            send(op, (op * 13 + f * 29) & 255, (op * 977 + f * 4111) & 16'hFFFF,
                 (((f ^ op) & 15) << 4) | f);
            if (f % 5 == 0) idle(op + f);
         end
      end

      // R7: displacement extremes and wrap at both ends of memory.
      send('h20, 'h7F, 'hFFFE, 0);
      send('h20, 'h80, 'h0000, 0);
      send('h20, 'h80, 'h0010, 0);
      send('h27, 'hFE, 'h4000, 'h04);
      send('h26, 'h7F, 'hFFF0, 'h04);

      // R8: subroutine form at memory top, both signed extremes, back to back.
      send('h8D, 'h7F, 'hFFFF, 'hA5);
      send('h8D, 'h80, 'hFFFE, 'h5A);
      send('h2F, 'h10, 'h2000, 'h00);
      send('h8D, 'h00, 'h1000, 'h0F);
      idle(99);

      // R9: opcodes outside the handled set.
      send('h00, 'h40, 'h3000, 'hFF);
      send('h1F, 'h40, 'hFFFF, 'h00);
      send('h30, 'h80, 'h1111, 'h0F);
      send('h8C, 'h01, 'h2222, 'hF0);
      send('h8E, 'hFF, 'h3333, 'h55);
      send('hFF, 'h7F, 'hFFFE, 'hAA);

      // R2: long idle with changing inputs must not move the outputs.
      for (int i = 0; i < 6; i++) idle(200 + i);
      chk_on = 1'b0;
      finish_run();
   end

endmodule